// File: doc/BRIEF.md
# Bank-Switching Memory Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and the memory devices. It widens every memory address to 20 bits and decodes active-low selects for one ROM region and one RAM region. The top nibble of the logical address indexes a 16-entry table of 8-bit page numbers. The chosen entry becomes physical address bits 19..12. The low twelve bits pass through unchanged.

Software loads the table with I/O writes to a mapping port. The entry to load is picked by address bits 15..12 of the I/O cycle; a CPU using a register-indirect OUT places its high register on those lines. The table holds no defined value after reset. The mapper therefore stays bypassed until software writes a 1 to bit 0 of a separate control port. While it is bypassed, the ROM answers at 0000H, where the CPU starts fetching. The bus is modelled as synchronous, active-high strobes sampled on the system clock. The block carries no data stream, so every pin is a plain level with no valid/ready handshake and no back-pressure.

Top module: `bank_mapper`

## Requirements
- R1: phys_addr[11:0] always equals cpu_addr[11:0] in the same cycle.
- R2: While mapping is enabled, phys_addr[19:12] equals the table entry indexed by cpu_addr[15:12] in the same cycle.
- R3: While mapping is disabled, phys_addr equals {4'h0, cpu_addr}. With mem_req high, rom_sel_n is low for cpu_addr[15:13] = 0 (the lowest 8 KB block) and ram_sel_n is low for the other seven blocks.
- R4: With mem_req low, both rom_sel_n and ram_sel_n are high. The two selects are never low together.
- R5: A cycle with io_req=1, wr=1 and cpu_addr[7:0]=8'h60 writes cpu_data into the entry indexed by cpu_addr[15:12]. The write happens at the clock edge where that condition is first seen.
- R6: A qualified write held high for several cycles writes only once, at its first edge. Data that changes later in the same strobe is ignored.
- R7: A cycle with io_req=1, wr=1 and cpu_addr[7:0]=8'h61 loads the enable bit from cpu_data[0] at its first edge, once per strobe. Reset clears the enable bit, so 0000H selects the ROM again after any reset.
- R8: While mapping is enabled and mem_req is high, rom_sel_n is low for physical pages 8'h00 and 8'h01, and ram_sel_n is low for all other pages.
- R9: An I/O write to any other port, an I/O cycle with wr=0, and a memory cycle with wr=1 leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | input | 1 | Memory request strobe, active high |
| io_req | input | 1 | I/O request strobe, active high |
| wr | input | 1 | Write strobe, active high |
| cpu_addr | input | 16 | Logical address bus |
| cpu_data | input | 8 | Data bus, carries values for table and control writes |
| phys_addr | output | 20 | Physical address |
| rom_sel_n | output | 1 | ROM select, active low |
| ram_sel_n | output | 1 | RAM select, active low |

## Verification
The physical address and both selects are combinational in the current address, mem_req and the stored state. They are due in the same cycle as the stimulus. Table writes and enable changes are registered at the first clock edge of a qualified strobe and show up in the cycle after that edge. The bench drives its inputs just after a rising edge and advances its model on that rising edge. It compares every output at the following falling edge, which is after the register update and in the same cycle as the combinational response.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
  localparam int LA_W   = 16;
  localparam int OFS_W  = 12;
  localparam int IDX_W  = LA_W - OFS_W;
  localparam int PAGE_W = 8;
  localparam int PA_W   = OFS_W + PAGE_W;
  localparam int DAT_W  = 8;
  localparam int ENTRIES = 1 << IDX_W;
  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/bmap_wr_ctrl.sv
module bmap_wr_ctrl
  import bmap_pkg::*;
#(
  parameter logic [7:0] MAP_PORT  = 8'h60,
  parameter logic [7:0] CTRL_PORT = 8'h61
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_req,
  input  logic       wr,
  input  logic [7:0] port,
  output logic       tbl_we,
  output logic       en_we
);
  localparam int NPORT = 2;
  localparam logic [7:0] PORT_LIST [NPORT] = '{MAP_PORT, CTRL_PORT};

  logic [NPORT-1:0] pulse;

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    logic hit, seen;
    assign hit = io_req && wr && (port == PORT_LIST[k]);
    always_ff @(posedge clk) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= hit;
    end
    assign pulse[k] = hit && !seen;

    // one update per strobe assertion
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[k] |=> !pulse[k]);
  end

  assign tbl_we = pulse[0];
  assign en_we  = pulse[1];
endmodule

// File: rtl/bmap_table.sv
module bmap_table
  import bmap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  idx_t  idx,
  input  page_t din,
  output page_t dout
);
  page_t slot [ENTRIES];

  // contents left undefined by reset on purpose
  always_ff @(posedge clk) begin
    if (we) slot[idx] <= din;
  end

  assign dout = slot[idx];

  assert_entry_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> slot[$past(idx)] == $past(din));
endmodule

// File: rtl/bmap_decode.sv
module bmap_decode
  import bmap_pkg::*;
#(
  parameter int ROM_PAGES = 2
) (
  input  logic            map_en,
  input  logic            mem_req,
  input  logic [LA_W-1:0] laddr,
  input  page_t           page_in,
  output logic [PA_W-1:0] paddr,
  output logic            rom_n,
  output logic            ram_n
);
  page_t page;
  logic  rom_hit;

  always_comb begin
    if (map_en) page = page_in;
    else        page = {{(PAGE_W-IDX_W){1'b0}}, laddr[LA_W-1:OFS_W]};
  end

  assign rom_hit = page < PAGE_W'(ROM_PAGES);
  assign paddr   = {page, laddr[OFS_W-1:0]};
  assign rom_n   = !(mem_req && rom_hit);
  assign ram_n   = !(mem_req && !rom_hit);
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bmap_pkg::*;
#(
  parameter logic [7:0] MAP_PORT  = 8'h60,
  parameter logic [7:0] CTRL_PORT = 8'h61,
  parameter int         ROM_PAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_req,
  input  logic             io_req,
  input  logic             wr,
  input  logic [LA_W-1:0]  cpu_addr,
  input  logic [DAT_W-1:0] cpu_data,
  output logic [PA_W-1:0]  phys_addr,
  output logic             rom_sel_n,
  output logic             ram_sel_n
);
  logic  tbl_we, en_we, map_en;
  page_t entry;

  bmap_wr_ctrl #(.MAP_PORT(MAP_PORT), .CTRL_PORT(CTRL_PORT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .wr(wr),
    .port(cpu_addr[7:0]), .tbl_we(tbl_we), .en_we(en_we));

  bmap_table u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we),
    .idx(cpu_addr[LA_W-1:OFS_W]), .din(cpu_data), .dout(entry));

  always_ff @(posedge clk) begin
    if (!rst_n)     map_en <= 1'b0;
    else if (en_we) map_en <= cpu_data[0];
  end

  bmap_decode #(.ROM_PAGES(ROM_PAGES)) u_dec (
    .map_en(map_en), .mem_req(mem_req), .laddr(cpu_addr), .page_in(entry),
    .paddr(phys_addr), .rom_n(rom_sel_n), .ram_n(ram_sel_n));

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]);
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !map_en |-> phys_addr == {{(PA_W-LA_W){1'b0}}, cpu_addr});
  assert_idle_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (rom_sel_n && ram_sel_n));
  assert_no_dual_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel_n || ram_sel_n);
  assert_enable_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> map_en == $past(cpu_data[0]));
endmodule

// File: tb/sim_bank_mapper.sv
module sim_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req = 1'b0, io_req = 1'b0, wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [19:0] phys_addr;
  logic        rom_sel_n, ram_sel_n;

  int checks = 0, fails = 0;
  string tag = "R3";

  always #10 clk = ~clk;

  bank_mapper u0 (.clk(clk), .rst_n(rst_n), .mem_req(mem_req), .io_req(io_req),
    .wr(wr), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .phys_addr(phys_addr),
    .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n));

  // behavioural model
  logic [7:0] m_tab [16];
  bit         m_val [16];
  bit         m_en, m_pm, m_pc;

  initial for (int i = 0; i < 16; i++) m_val[i] = 1'b0;

  always @(posedge clk) begin
    bit hm, hc;
    if (!rst_n) begin
      m_en = 1'b0; m_pm = 1'b0; m_pc = 1'b0;
    end else begin
      hm = io_req && wr && cpu_addr[7:0] == 8'h60;
      hc = io_req && wr && cpu_addr[7:0] == 8'h61;
      if (hm && !m_pm) begin
        m_tab[cpu_addr[15:12]] = cpu_data;
        m_val[cpu_addr[15:12]] = 1'b1;
      end
      if (hc && !m_pc) m_en = cpu_data[0];
      m_pm = hm; m_pc = hc;
    end
  end

  always @(negedge clk) begin
    logic [7:0]  pg;
    logic [19:0] ep;
    bit known, erom, eram;
    if (rst_n) begin
      known = 1'b1;
      if (m_en) begin
        known = m_val[cpu_addr[15:12]];
        pg = m_tab[cpu_addr[15:12]];
      end else pg = {4'h0, cpu_addr[15:12]};
      if (known) begin
        ep = {pg, cpu_addr[11:0]};
        erom = !(mem_req && pg < 8'd2);
        eram = !(mem_req && pg >= 8'd2);
        checks++;
        if (phys_addr !== ep) begin
          fails++;
          $display("FAIL %s/%s phys_addr actual %h expected %h", tag,
                   m_en ? "R2" : "R3", phys_addr, ep);
        end
        checks++;
        if (rom_sel_n !== erom || ram_sel_n !== eram) begin
          fails++;
          $display("FAIL %s/%s selects actual rom=%b ram=%b expected rom=%b ram=%b",
                   tag, !mem_req ? "R4" : (m_en ? "R8" : "R3"),
                   rom_sel_n, ram_sel_n, erom, eram);
        end
      end
    end
  end

  task automatic bus(input bit m, input bit io, input bit w,
                     input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    mem_req = m; io_req = io; wr = w; cpu_addr = a; cpu_data = d;
  endtask

  task automatic idle();
    bus(1'b0, 1'b0, 1'b0, 16'h0000, 8'h00);
  endtask

  function automatic logic [7:0] val(input int i);
    case (i)
      3:       return 8'h01;
      9:       return 8'h00;
      default: return 8'(8'h20 + i * 11);
    endcase
  endfunction

  initial begin : wd
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R3: bypassed after reset, ROM at 0000H
    tag = "R3";
    bus(1'b1, 1'b0, 1'b0, 16'h0000, 8'h00);
    bus(1'b1, 1'b0, 1'b0, 16'h1FFF, 8'h00);
    bus(1'b1, 1'b0, 1'b0, 16'h2000, 8'h00);
    bus(1'b1, 1'b0, 1'b0, 16'hF123, 8'h00);
    tag = "R4"; idle(); idle();
    // R5: load all entries
    tag = "R5";
    for (int i = 0; i < 16; i++) begin
      bus(1'b0, 1'b1, 1'b1, {4'(i), 4'h0, 8'h60}, val(i));
      idle();
    end
    // R9: writes that must not touch the table
    tag = "R9";
    bus(1'b0, 1'b1, 1'b1, 16'h2062, 8'hAA); idle();
    bus(1'b0, 1'b1, 1'b0, 16'h2060, 8'hAA); idle();
    bus(1'b1, 1'b0, 1'b1, 16'h2060, 8'hAA); idle();
    // R6: held strobe, later data ignored
    tag = "R6";
    bus(1'b0, 1'b1, 1'b1, 16'h7060, 8'h33);
    bus(1'b0, 1'b1, 1'b1, 16'h7060, 8'h99);
    bus(1'b0, 1'b1, 1'b1, 16'h7060, 8'h55);
    idle();
    // R7: enable
    tag = "R7";
    bus(1'b0, 1'b1, 1'b1, 16'h0061, 8'h01); idle();
    // R2/R8 sweep, covers R6 (entry 7) and R9 (entry 2)
    tag = "R2";
    for (int i = 0; i < 16; i++) begin
      bus(1'b1, 1'b0, 1'b0, {4'(i), 12'hABC}, 8'h00);
      bus(1'b1, 1'b0, 1'b1, {4'(i), 12'h000}, 8'h00);
    end
    tag = "R8";
    bus(1'b1, 1'b0, 1'b0, 16'h3FFF, 8'h00);
    bus(1'b1, 1'b0, 1'b0, 16'h9000, 8'h00);
    tag = "R1";
    bus(1'b0, 1'b0, 1'b0, 16'h5A5A, 8'h00);
    // R7: disable with bit0 = 0
    tag = "R7";
    bus(1'b0, 1'b1, 1'b1, 16'h0061, 8'hFE); idle();
    bus(1'b1, 1'b0, 1'b0, 16'h5000, 8'h00);
    bus(1'b0, 1'b1, 1'b1, 16'h0061, 8'h01); idle();
    bus(1'b1, 1'b0, 1'b0, 16'h3000, 8'h00);
    // R7: reset returns ROM to 0000H
    @(posedge clk); #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    bus(1'b1, 1'b0, 1'b0, 16'h0000, 8'h00);
    bus(1'b1, 1'b0, 1'b0, 16'h3000, 8'h00);
    idle(); idle();
    @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule